// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block is the digital fault manager of a three-phase gate driver. It takes flags from the analog comparators: main and logic supply undervoltage, charge-pump undervoltage, buck undervoltage, overvoltage, phase overcurrent, buck overcurrent, thermal warning, thermal shutdown and FET thermal shutdown. It also takes a serial-interface error flag, a one-time-memory read error flag and the hall sensor lines. From these it drives three outputs: an active-low fault pin, a status word with one sticky bit per fault, and a force signal that puts every power FET in Hi-Z.

Each fault has its own recovery policy. A fault can latch until cleared, re-enable after a timed retry, recover automatically when its flag drops, or only report. Each fault also decides on its own whether it forces Hi-Z and whether it drives the fault pin. The retry timers and the hall-edge lock detector are counters clocked by the system clock, and their lengths are parameters.

Two commands clear faults: a clear command and a sleep reset pulse. The sleep pulse can do everything the clear command does, and it is the only way to release a memory read error.

Top module: `mtr_fault_sup`

## Requirements
- R1: After `rst_n` is released, `status_o` reads 12'h001 (only the power-on bit 0 is set), `fault_n_o` is 1 and `hiz_o` is 0.
- R2: While `vm_uv_i` or `avdd_uv_i` is high, `hiz_o` is 1 and `fault_n_o` is 1. All latches, timers and status bits are held cleared. On the clock edge after the undervoltage goes away, status bit 0 is set.
- R3: With `oc_retry_i`=0, phase overcurrent forces `hiz_o`=1 and `fault_n_o`=0. This stays latched after the flag drops, until a clock edge with `clr_i` or `slp_rst_i` high and `oc_i` low.
- R4: With `oc_retry_i`=1, phase overcurrent forces `hiz_o`=1 and `fault_n_o`=0. If the flag is sampled high at edge k and low afterwards, the outputs release after edge k+OC_RETRY_CYC. If the flag is still high when the count expires, the count starts again.
- R5: The hall lines pass through a two-flop synchronizer. Any edge on any line restarts the lock counter. A lock is declared once the counter reaches LOCK_DET_CYC cycles with no edge. With `lock_mode_i`=2'b00 the lock forces Hi-Z and the fault pin, and it stays latched until a clear arrives while no lock is present. With 2'b01 the lock forces Hi-Z for LOCK_RETRY_CYC cycles with the lock counter held, and then it rearms.
- R6: With `lock_mode_i`=2'b10 a lock drives only the fault pin and never forces Hi-Z. With 2'b11 a lock has no effect, and status bit 8 is not set.
- R7: Overvoltage has no effect on any output when `ov_en_i`=0. When `ov_en_i`=1 it forces Hi-Z and the fault pin while `ov_i` is high.
- R8: Charge-pump undervoltage forces Hi-Z and the fault pin. Buck undervoltage drives only the fault pin. Buck overcurrent drives only the fault pin, and keeps it low until BUCK_RETRY_CYC edges after the flag was last sampled high.
- R9: A memory read error forces Hi-Z and the fault pin and latches. `clr_i` has no effect on the latch or on status bit 7. A `slp_rst_i` edge with the flag low releases both.
- R10: The thermal warning drives the fault pin only when `tw_rep_i`=1 and never forces Hi-Z. Thermal shutdown and FET thermal shutdown force Hi-Z and the fault pin while their flags are high.
- R11: A serial-interface error drives the fault pin when `spi_quiet_i`=0. When `spi_quiet_i`=1 it leaves the pin high. It never forces Hi-Z.
- R12: A status bit is set on the edge after its condition is seen. It clears only on a clear edge where the condition is absent. Bit map: 0 power-on, 1 charge-pump UV, 2 buck UV, 3 overvoltage (enabled only), 4 phase OC, 5 buck OC, 6 serial error, 7 memory error, 8 lock, 9 thermal warning, 10 thermal shutdown, 11 FET thermal shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vm_uv_i | input | 1 | Main supply undervoltage flag |
| avdd_uv_i | input | 1 | Logic supply undervoltage flag |
| cp_uv_i | input | 1 | Charge-pump undervoltage flag |
| buck_uv_i | input | 1 | Buck undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| oc_i | input | 1 | Phase overcurrent flag |
| buck_oc_i | input | 1 | Buck overcurrent flag |
| tw_i | input | 1 | Thermal warning flag |
| tsd_i | input | 1 | Thermal shutdown flag |
| tsd_fet_i | input | 1 | FET thermal shutdown flag |
| spi_err_i | input | 1 | Serial-interface error flag |
| otp_err_i | input | 1 | One-time memory read error flag |
| hall_i | input | NUM_HALL | Asynchronous hall sensor lines |
| clr_i | input | 1 | Clear-fault command |
| slp_rst_i | input | 1 | Sleep reset pulse |
| ov_en_i | input | 1 | Overvoltage handling enable |
| oc_retry_i | input | 1 | Phase overcurrent policy: 0 latched, 1 timed retry |
| lock_mode_i | input | 2 | Lock policy: 00 latch, 01 retry, 10 report, 11 off |
| tw_rep_i | input | 1 | Thermal warning drives fault pin |
| spi_quiet_i | input | 1 | Serial error kept off the fault pin |
| fault_n_o | output | 1 | Active-low fault pin |
| hiz_o | output | 1 | Force all power FETs to Hi-Z |
| status_o | output | 12 | Sticky fault status bits |

## Verification
The assertions assume that the comparator flags and configuration inputs are synchronous to `clk` and stable between edges. They assume that the clear command and the sleep pulse are never active in the same cycle as a supply undervoltage, and that a configuration field changes only when the fault it governs is idle. The stimulus drives every flag, mode and command on the falling edge, one fault class at a time, and returns each to idle before changing its mode. The hall lines are the only asynchronous inputs, and the synchronizer takes them in.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  localparam int NSTAT = 12;

  localparam int S_POR  = 0;
  localparam int S_CPUV = 1;
  localparam int S_BKUV = 2;
  localparam int S_OV   = 3;
  localparam int S_OC   = 4;
  localparam int S_BKOC = 5;
  localparam int S_SPI  = 6;
  localparam int S_OTP  = 7;
  localparam int S_LOCK = 8;
  localparam int S_TW   = 9;
  localparam int S_TSD  = 10;
  localparam int S_TSDF = 11;

  typedef enum logic [1:0] {
    LK_LATCH  = 2'b00,
    LK_RETRY  = 2'b01,
    LK_REPORT = 2'b10,
    LK_OFF    = 2'b11
  } lock_mode_e;

  // set wins over clear; clear only acts where its mask bit is high
  function automatic logic [NSTAT-1:0] sticky_next(input logic [NSTAT-1:0] cur,
                                                   input logic [NSTAT-1:0] set,
                                                   input logic [NSTAT-1:0] clr_mask);
    return set | (cur & ~clr_mask);
  endfunction
endpackage

// File: rtl/mfs_retry.sv
module mfs_retry #(
  parameter int LEN = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic trig,
  output logic busy_o
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;

  logic [W-1:0] cnt;
  logic         busy;
  logic         expire;

  assign expire = busy && (cnt == W'(LEN - 1));
  assign busy_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (srst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (trig) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (expire) begin
      busy <= trig;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= W'(LEN - 1)));
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire && !srst) |=> busy);
endmodule

// File: rtl/mfs_hall_mon.sv
module mfs_hall_mon #(
  parameter int NUM_HALL = 3,
  parameter int LOCK_CYC = 50000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst,
  input  logic                hold,
  input  logic [NUM_HALL-1:0] hall_i,
  output logic                lock_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [NUM_HALL-1:0] s1, s2, s3;
  logic [CW-1:0]       cnt;
  logic                hall_edge;

  assign hall_edge = |(s2 ^ s3);
  assign lock_o    = (cnt == CW'(LOCK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= hall_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (srst || hold || hall_edge) cnt <= '0;
    else if (!lock_o)                   cnt <= cnt + 1'b1;
  end

  p_edge_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hall_edge |=> (cnt == '0));
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LOCK_CYC));
endmodule

// File: rtl/mtr_fault_sup.sv
module mtr_fault_sup
  import mfs_pkg::*;
#(
  parameter int NUM_HALL        = 3,
  parameter int OC_RETRY_CYC    = 4000,
  parameter int BUCK_RETRY_CYC  = 2000,
  parameter int LOCK_RETRY_CYC  = 4000,
  parameter int LOCK_DET_CYC    = 50000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vm_uv_i,
  input  logic                avdd_uv_i,
  input  logic                cp_uv_i,
  input  logic                buck_uv_i,
  input  logic                ov_i,
  input  logic                oc_i,
  input  logic                buck_oc_i,
  input  logic                tw_i,
  input  logic                tsd_i,
  input  logic                tsd_fet_i,
  input  logic                spi_err_i,
  input  logic                otp_err_i,
  input  logic [NUM_HALL-1:0] hall_i,
  input  logic                clr_i,
  input  logic                slp_rst_i,
  input  logic                ov_en_i,
  input  logic                oc_retry_i,
  input  logic [1:0]          lock_mode_i,
  input  logic                tw_rep_i,
  input  logic                spi_quiet_i,
  output logic                fault_n_o,
  output logic                hiz_o,
  output logic [NSTAT-1:0]    status_o
);
  lock_mode_e       lk_mode;
  logic             sup_uv, uv_q, por_set, clr_any;
  logic             oc_lat, otp_lat, lock_lat;
  logic             oc_busy, bk_busy, lk_busy, lock_det;
  logic             ov_act, oc_act, bk_act, otp_act, lk_hiz, lk_rep;
  logic [NSTAT-1:0] present, clr_mask, status;

  assign lk_mode = lock_mode_e'(lock_mode_i);
  assign sup_uv  = vm_uv_i | avdd_uv_i;
  assign por_set = uv_q & ~sup_uv;
  assign clr_any = clr_i | slp_rst_i;

  mfs_retry #(.LEN(OC_RETRY_CYC)) u_oc_rty (
    .clk(clk), .rst_n(rst_n), .srst(sup_uv),
    .trig(oc_i & oc_retry_i), .busy_o(oc_busy));

  mfs_retry #(.LEN(BUCK_RETRY_CYC)) u_bk_rty (
    .clk(clk), .rst_n(rst_n), .srst(sup_uv),
    .trig(buck_oc_i), .busy_o(bk_busy));

  mfs_retry #(.LEN(LOCK_RETRY_CYC)) u_lk_rty (
    .clk(clk), .rst_n(rst_n), .srst(sup_uv),
    .trig(lock_det && (lk_mode == LK_RETRY)), .busy_o(lk_busy));

  mfs_hall_mon #(.NUM_HALL(NUM_HALL), .LOCK_CYC(LOCK_DET_CYC)) u_hall (
    .clk(clk), .rst_n(rst_n), .srst(sup_uv), .hold(lk_busy),
    .hall_i(hall_i), .lock_o(lock_det));

  // latched policies: set has priority over any clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_lat   <= 1'b0;
      otp_lat  <= 1'b0;
      lock_lat <= 1'b0;
      uv_q     <= 1'b0;
    end else begin
      uv_q <= sup_uv;
      if (sup_uv) begin
        oc_lat   <= 1'b0;
        otp_lat  <= 1'b0;
        lock_lat <= 1'b0;
      end else begin
        if (oc_i && !oc_retry_i)                   oc_lat <= 1'b1;
        else if (clr_any)                          oc_lat <= 1'b0;
        if (otp_err_i)                             otp_lat <= 1'b1;
        else if (slp_rst_i)                        otp_lat <= 1'b0;
        if (lock_det && (lk_mode == LK_LATCH))     lock_lat <= 1'b1;
        else if (clr_any)                          lock_lat <= 1'b0;
      end
    end
  end

  assign ov_act  = ov_en_i & ov_i;
  assign oc_act  = oc_i | oc_lat | oc_busy;
  assign bk_act  = buck_oc_i | bk_busy;
  assign otp_act = otp_err_i | otp_lat;
  assign lk_hiz  = lock_lat | lk_busy |
                   (lock_det && (lk_mode == LK_LATCH || lk_mode == LK_RETRY));
  assign lk_rep  = lk_hiz | (lock_det && (lk_mode == LK_REPORT));

  always_comb begin
    present         = '0;
    present[S_POR]  = por_set;
    present[S_CPUV] = cp_uv_i;
    present[S_BKUV] = buck_uv_i;
    present[S_OV]   = ov_act;
    present[S_OC]   = oc_i;
    present[S_BKOC] = buck_oc_i;
    present[S_SPI]  = spi_err_i;
    present[S_OTP]  = otp_err_i;
    present[S_LOCK] = lock_det && (lk_mode != LK_OFF);
    present[S_TW]   = tw_i;
    present[S_TSD]  = tsd_i;
    present[S_TSDF] = tsd_fet_i;
    clr_mask        = {NSTAT{clr_any}};
    clr_mask[S_OTP] = slp_rst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= NSTAT'(1) << S_POR;
    else if (sup_uv) status <= '0;
    else             status <= sticky_next(status, present, clr_mask);
  end

  assign status_o  = status;
  assign hiz_o     = sup_uv | cp_uv_i | ov_act | oc_act | otp_act |
                     lk_hiz | tsd_i | tsd_fet_i;
  assign fault_n_o = sup_uv | ~(cp_uv_i | buck_uv_i | ov_act | oc_act | bk_act |
                     otp_act | lk_rep | (tw_i & tw_rep_i) | tsd_i | tsd_fet_i |
                     (spi_err_i & ~spi_quiet_i));

  p_uv_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sup_uv |-> (hiz_o && fault_n_o));
  p_por_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_uv) |=> status_o[S_POR]);
  p_oc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lat && !clr_any && !sup_uv) |=> oc_lat);
  p_otp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_lat && !slp_rst_i && !sup_uv) |=> (otp_lat && status_o[S_OTP]));
  p_tw_nohiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_o && !sup_uv) |-> (cp_uv_i || ov_i || oc_act || otp_act || lk_hiz ||
                            tsd_i || tsd_fet_i));
endmodule

// File: tb/test_mtr_fault_sup.sv
module test_mtr_fault_sup;
  localparam int OCR = 8;
  localparam int BKR = 5;
  localparam int LKR = 8;
  localparam int LKD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vm_uv = 0, avdd_uv = 0, cp_uv = 0, buck_uv = 0, ov = 0, oc = 0, buck_oc = 0;
  logic tw = 0, tsd = 0, tsd_fet = 0, spi = 0, otp = 0, clr = 0, slp = 0;
  logic ov_en = 0, oc_retry = 0, tw_rep = 0, spi_quiet = 0;
  logic [1:0]  lock_mode = 2'b11;
  logic [2:0]  hall = 3'b000;
  logic        fault_n, hiz;
  logic [11:0] status;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mtr_fault_sup #(.NUM_HALL(3), .OC_RETRY_CYC(OCR), .BUCK_RETRY_CYC(BKR),
                  .LOCK_RETRY_CYC(LKR), .LOCK_DET_CYC(LKD)) i_mtr_fault_sup (
    .clk(clk), .rst_n(rst_n), .vm_uv_i(vm_uv), .avdd_uv_i(avdd_uv),
    .cp_uv_i(cp_uv), .buck_uv_i(buck_uv), .ov_i(ov), .oc_i(oc),
    .buck_oc_i(buck_oc), .tw_i(tw), .tsd_i(tsd), .tsd_fet_i(tsd_fet),
    .spi_err_i(spi), .otp_err_i(otp), .hall_i(hall), .clr_i(clr),
    .slp_rst_i(slp), .ov_en_i(ov_en), .oc_retry_i(oc_retry),
    .lock_mode_i(lock_mode), .tw_rep_i(tw_rep), .spi_quiet_i(spi_quiet),
    .fault_n_o(fault_n), .hiz_o(hiz), .status_o(status));

  // flags [6:0] = {spi, tsd_fet, tsd, tw, ov, buck_uv, cp_uv}; cfg [2:0] = {spi_quiet, tw_rep, ov_en}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {7'b0000001, 3'b000, 1'b0, 1'b1, 12'h002},
    {7'b0000010, 3'b000, 1'b0, 1'b0, 12'h004},
    {7'b0000100, 3'b000, 1'b1, 1'b0, 12'h000},
    {7'b0000100, 3'b001, 1'b0, 1'b1, 12'h008},
    {7'b0001000, 3'b000, 1'b1, 1'b0, 12'h200},
    {7'b0001000, 3'b010, 1'b0, 1'b0, 12'h200},
    {7'b0010000, 3'b000, 1'b0, 1'b1, 12'h400},
    {7'b0100000, 3'b000, 1'b0, 1'b1, 12'h800},
    {7'b1000000, 3'b000, 1'b0, 1'b0, 12'h040},
    {7'b1000000, 3'b100, 1'b1, 1'b0, 12'h040},
    {7'b0000000, 3'b000, 1'b1, 1'b0, 12'h000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1; cyc(1); clr = 0; #1;
  endtask

  task automatic pulse_slp();
    slp = 1; cyc(1); slp = 0; #1;
  endtask

  task automatic toggle_hall(input int n);
    for (int i = 0; i < n; i++) begin
      hall[i % 3] = ~hall[i % 3];
      cyc(3);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 status", status, 12'h001);
    chk("R1 fault_n", fault_n, 1);
    chk("R1 hiz", hiz, 0);
    pulse_clr();
    chk("R12 por cleared", status, 12'h000);

    // table walk: R7 R8 R10 R11 outputs, R12 sticky status
    for (int k = 0; k < NV; k++) begin
      {spi, tsd_fet, tsd, tw, ov, buck_uv, cp_uv} = VEC[k][23:17];
      {spi_quiet, tw_rep, ov_en} = VEC[k][16:14];
      #1;
      chk($sformatf("R7/R8/R10/R11 fault_n vec%0d", k), fault_n, VEC[k][13]);
      chk($sformatf("R7/R8/R10/R11 hiz vec%0d", k), hiz, VEC[k][12]);
      cyc(1);
      {spi, tsd_fet, tsd, tw, ov, buck_uv, cp_uv} = 7'b0;
      #1;
      chk($sformatf("R12 sticky vec%0d", k), status, VEC[k][11:0]);
      pulse_clr();
      chk($sformatf("R12 cleared vec%0d", k), status, 12'h000);
      {spi_quiet, tw_rep, ov_en} = 3'b000;
    end

    // R12 clear while condition present does not clear
    tsd = 1; cyc(1); clr = 1; cyc(1); clr = 0; #1;
    chk("R12 clear with cond present", status, 12'h400);
    tsd = 0; pulse_clr();

    // R3 latched phase overcurrent
    oc_retry = 0; oc = 1; #1;
    chk("R3 hiz on", hiz, 1);
    cyc(1); clr = 1; cyc(1); oc = 0; clr = 0; #1;
    chk("R3 clear with flag high ignored", hiz, 1);
    cyc(2);
    chk("R3 latched fault_n", fault_n, 0);
    pulse_clr();
    chk("R3 released hiz", hiz, 0);
    chk("R3 released fault_n", fault_n, 1);
    chk("R3 status bit4 cleared", status[4], 0);
    oc = 1; cyc(1); oc = 0; #1;
    chk("R3 latched again", hiz, 1);
    pulse_slp();
    chk("R3 sleep releases", hiz, 0);

    // R4 retry phase overcurrent, single sample
    oc_retry = 1; oc = 1; cyc(1); oc = 0;
    cyc(OCR - 1);
    chk("R4 still off before expiry", hiz, 1);
    cyc(1);
    chk("R4 released at expiry", hiz, 0);
    // R4 restart when flag present at expiry
    oc = 1; cyc(OCR + 1); oc = 0;
    cyc(OCR - 1);
    chk("R4 restarted still off", hiz, 1);
    cyc(1);
    chk("R4 restarted released", hiz, 0);
    chk("R4 fault_n back", fault_n, 1);
    oc_retry = 0; pulse_clr();

    // R8 buck overcurrent retry
    buck_oc = 1; cyc(1); buck_oc = 0;
    cyc(BKR - 1);
    chk("R8 buck oc fault_n held", fault_n, 0);
    chk("R8 buck oc no hiz", hiz, 0);
    cyc(1);
    chk("R8 buck oc released", fault_n, 1);
    pulse_clr();

    // R9 memory error: clear command has no effect, sleep releases
    otp = 1; cyc(1); otp = 0; #1;
    chk("R9 hiz", hiz, 1);
    pulse_clr();
    chk("R9 clr ignored hiz", hiz, 1);
    chk("R9 clr ignored fault_n", fault_n, 0);
    chk("R9 clr ignored status", status[7], 1);
    pulse_slp();
    chk("R9 sleep releases hiz", hiz, 0);
    chk("R9 sleep clears status", status, 12'h000);

    // R5 lock latched mode
    toggle_hall(2);
    lock_mode = 2'b00;
    toggle_hall(5);
    chk("R5 no lock while hall moves", fault_n, 1);
    cyc(LKD + 6);
    chk("R5 lock hiz", hiz, 1);
    chk("R5 lock fault_n", fault_n, 0);
    chk("R5 lock status", status[8], 1);
    pulse_clr();
    chk("R5 clear during lock ignored", hiz, 1);
    toggle_hall(1);
    pulse_clr();
    chk("R5 lock released", hiz, 0);
    chk("R5 lock status cleared", status[8], 0);
    lock_mode = 2'b11;

    // R5 lock retry mode
    toggle_hall(1);
    lock_mode = 2'b01;
    for (int i = 0; i < 40 && !hiz; i++) cyc(1);
    chk("R5 retry lock seen", hiz, 1);
    cyc(12);
    chk("R5 retry re-enabled", hiz, 0);
    cyc(20);
    chk("R5 retry rearmed", hiz, 1);
    lock_mode = 2'b11;
    cyc(LKR + 2);

    // R6 report and off modes
    toggle_hall(1);
    lock_mode = 2'b10;
    cyc(LKD + 6);
    chk("R6 report fault_n", fault_n, 0);
    chk("R6 report no hiz", hiz, 0);
    lock_mode = 2'b11; #1;
    pulse_clr();
    chk("R6 off fault_n", fault_n, 1);
    chk("R6 off hiz", hiz, 0);
    chk("R6 off status", status[8], 0);

    // R2 supply undervoltage
    tsd = 1; vm_uv = 1; #1;
    chk("R2 hiz", hiz, 1);
    chk("R2 fault_n", fault_n, 1);
    cyc(1);
    chk("R2 status held clear", status, 12'h000);
    tsd = 0; vm_uv = 0; avdd_uv = 1; cyc(1);
    avdd_uv = 0; #1;
    chk("R2 still clear", status, 12'h000);
    cyc(1);
    chk("R2 por set", status, 12'h001);
    chk("R2 outputs idle", {fault_n, hiz}, 2'b10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule